// File: doc/BRIEF.md
# ADC Input Mode Configuration and Channel Legality Check

This block holds one configuration bit per analog input channel. The bit selects whether the channel is converted single-ended, against the negative reference, or differentially, against the next-higher input. Software programs the bits through a small register port. The port accepts a new setting only while the converter reports itself disabled. A write that arrives while the converter is running is discarded, and a sticky flag records the loss.

The lowest bit and the highest `NUM_FIXED` channels cannot be written. The top channels are internal sources, so they stay single-ended at all times.

A conversion sequencer asks the block about a channel number and gets back a combinational answer with two parts:
- whether the channel may be converted at all;
- if it may, whether the conversion is differential.

A channel is refused in two cases:
- its number lies beyond the implemented range;
- the channel just below it is differential, which means this channel's pin already serves as that neighbour's negative input.

Top module: `adc_chanmode_cfg`

## Requirements
- R1: After reset, the mode register (address 0) and the status register (address 1) both read as zero, so every channel starts single-ended.
- R2: While `conv_en` is 0, a write to address 0 loads bits 1 to NUM_CH-NUM_FIXED-1 (1 to 15 by default) from the write data. A 1 means differential and a 0 means single-ended. The new value is visible on `rd_data` from the clock edge after the write.
- R3: Bit 0 and the top NUM_FIXED channel bits (16 to 18 by default) of the mode register always read 0, whatever value is written.
- R4: A write to address 0 while `conv_en` is 1 leaves the mode register unchanged.
- R5: A write dropped under R4 sets status bit 0 (the lock-violation flag) on the next edge. The flag stays set until it is cleared.
- R6: Writing a 1 in bit 0 to address 1 clears the lock-violation flag. Writing a 0 there leaves the flag unchanged.
- R7: A query with `q_chan` greater than or equal to NUM_CH (19 by default) returns `q_legal`=0.
- R8: A query for channel j (j ≥ 1) returns `q_legal`=0 whenever the mode bit of channel j-1 is 1. This holds whatever channel j's own bit is.
- R9: For a legal channel, `q_diff` equals that channel's mode bit (1 = differential). For an illegal query, `q_diff` is 0.
- R10: A read of any address other than 0 and 1 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Register address for reads and writes (0 = mode, 1 = status) |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| conv_en | input | 1 | Converter enable status; 1 locks the mode register |
| q_chan | input | CH_W | Channel number under query |
| q_legal | output | 1 | 1 when the queried channel may be converted |
| q_diff | output | 1 | Mode to use for a legal channel (1 = differential) |

## Verification
The bench builds the block with its defaults: 19 channels, 3 fixed top channels, 32-bit data and a 2-bit address. With these values the 5-bit channel number reaches 19 to 31, so the out-of-range refusal can be driven from the port. They also put the writable-to-fixed border between channels 15 and 16. A differential channel 15 must block channel 16. Channel 17 and channel 18 must stay legal, because the fixed bits below them can never block them.

// File: rtl/adc_chanmode_pkg.sv
package adc_chanmode_pkg;

    // Register offsets on the configuration port
    localparam int unsigned OFS_MODE = 0;
    localparam int unsigned OFS_STAT = 1;

    // Bit position of the lock-violation flag in the status register
    localparam int unsigned STAT_LOCK_BIT = 0;

    // Largest channel count the mask helper supports
    localparam int unsigned MAX_CH = 64;

    // Mask of the software-writable mode bits: bit 0 is reserved and
    // the top nfixed channels are hard-wired single-ended.
    function automatic logic [MAX_CH-1:0] writable_mask(int unsigned nch,
                                                       int unsigned nfixed);
        logic [MAX_CH-1:0] m;
        m = '0;
        for (int unsigned i = 1; i < MAX_CH; i++) begin
            if (i + nfixed < nch) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/adc_chanmode_regs.sv
module adc_chanmode_regs
    import adc_chanmode_pkg::*;
#(
    parameter int unsigned NUM_CH    = 19,
    parameter int unsigned NUM_FIXED = 3,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              conv_en,
    output logic [NUM_CH-1:0] mode_o,
    output logic              lock_err_o
);

    localparam logic [MAX_CH-1:0] MASK_FULL = writable_mask(NUM_CH, NUM_FIXED);
    localparam logic [NUM_CH-1:0] WR_MASK   = MASK_FULL[NUM_CH-1:0];
    localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFS_STAT);

    typedef struct packed {
        logic [NUM_CH-1:0] mode;
        logic              lock_err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic mode_wr;
    logic stat_wr;

    always_comb begin
        mode_wr = wr_en && (addr == A_MODE);
        stat_wr = wr_en && (addr == A_STAT);
        st_d    = st_q;
        if (mode_wr) begin
            if (conv_en) begin
                st_d.lock_err = 1'b1;
            end else begin
                st_d.mode = wr_data[NUM_CH-1:0] & WR_MASK;
            end
        end else if (stat_wr && wr_data[STAT_LOCK_BIT]) begin
            st_d.lock_err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign lock_err_o = st_q.lock_err;

endmodule

// File: rtl/adc_chanmode_rdmux.sv
module adc_chanmode_rdmux
    import adc_chanmode_pkg::*;
#(
    parameter int unsigned NUM_CH = 19,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] mode,
    input  logic              lock_err,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    always_comb begin
        rd_data = '0;
        if (addr == A_MODE) begin
            rd_data[NUM_CH-1:0] = mode;
        end else if (addr == A_STAT) begin
            rd_data[STAT_LOCK_BIT] = lock_err;
        end
    end

endmodule

// File: rtl/adc_chanmode_query.sv
module adc_chanmode_query #(
    parameter int unsigned NUM_CH = 19,
    parameter int unsigned CH_W   = $clog2(NUM_CH + 1)
) (
    input  logic [NUM_CH-1:0] mode,
    input  logic [CH_W-1:0]   q_chan,
    output logic              q_legal,
    output logic              q_diff
);

    // A channel is taken when the channel below it is differential
    logic [NUM_CH-1:0] taken;

    assign taken[0] = 1'b0;
    for (genvar j = 1; j < NUM_CH; j++) begin : g_taken
        assign taken[j] = mode[j-1];
    end

    always_comb begin
        q_legal = 1'b0;
        q_diff  = 1'b0;
        if (int'(q_chan) < int'(NUM_CH)) begin
            q_legal = !taken[q_chan];
            q_diff  = q_legal && mode[q_chan];
        end
    end

endmodule

// File: rtl/adc_chanmode_cfg.sv
module adc_chanmode_cfg #(
    parameter int unsigned NUM_CH    = 19,
    parameter int unsigned NUM_FIXED = 3,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned CH_W      = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              conv_en,
    input  logic [CH_W-1:0]   q_chan,
    output logic              q_legal,
    output logic              q_diff
);

    logic [NUM_CH-1:0] mode_q;
    logic              err_q;

    adc_chanmode_regs #(
        .NUM_CH   (NUM_CH),
        .NUM_FIXED(NUM_FIXED),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .conv_en   (conv_en),
        .mode_o    (mode_q),
        .lock_err_o(err_q)
    );

    adc_chanmode_rdmux #(
        .NUM_CH(NUM_CH),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_rdmux (
        .addr    (addr),
        .mode    (mode_q),
        .lock_err(err_q),
        .rd_data (rd_data)
    );

    adc_chanmode_query #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W)
    ) u_query (
        .mode   (mode_q),
        .q_chan (q_chan),
        .q_legal(q_legal),
        .q_diff (q_diff)
    );

endmodule

// File: rtl/adc_chanmode_chk.sv
module adc_chanmode_chk #(
    parameter int unsigned NUM_CH    = 19,
    parameter int unsigned NUM_FIXED = 3,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned CH_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              conv_en,
    input logic [CH_W-1:0]   q_chan,
    input logic              q_legal,
    input logic              q_diff,
    input logic [NUM_CH-1:0] mode_q,
    input logic              err_q
);

    localparam int unsigned TOPW = NUM_CH - NUM_FIXED - 1;

    // R2: an unlocked write lands in the writable bits
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && !conv_en)
        |=> mode_q[TOPW:1] == $past(wr_data[TOPW:1]));

    // R3: reserved and hard-wired bits stay zero
    a_r3_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[0] && mode_q[NUM_CH-1:NUM_CH-NUM_FIXED] == '0);

    // R4: locked write leaves the register alone
    a_r4_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && conv_en) |=> $stable(mode_q));

    // R5: locked write raises the sticky flag
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && conv_en) |=> err_q);

    // R6: a clear write drops the flag
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1) && wr_data[0]) |=> !err_q);

    // R7: out-of-range channels are refused
    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_chan) >= int'(NUM_CH)) |-> !q_legal);

    // R8: a differential neighbour below takes the channel
    a_r8_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_chan) >= 1 && int'(q_chan) < int'(NUM_CH)
         && mode_q[q_chan - CH_W'(1)]) |-> !q_legal);

    // R9: refused channels report no mode
    a_r9_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !q_legal |-> !q_diff);

endmodule

bind adc_chanmode_cfg adc_chanmode_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_FIXED(NUM_FIXED),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CH_W     (CH_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .conv_en(conv_en),
    .q_chan (q_chan),
    .q_legal(q_legal),
    .q_diff (q_diff),
    .mode_q (mode_q),
    .err_q  (err_q)
);

// File: tb/sim_adc_chanmode_cfg.sv
module sim_adc_chanmode_cfg;

    localparam int NCH = 19;
    localparam int DW  = 32;
    localparam int AW  = 2;
    localparam int CW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          conv_en = 1'b0;
    logic [CW-1:0] q_chan = '0;
    logic          q_legal;
    logic          q_diff;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_chanmode_cfg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .conv_en(conv_en),
        .q_chan(q_chan), .q_legal(q_legal), .q_diff(q_diff)
    );

    // Query vectors {chan, legal, diff} for mode value 0x8062
    // (differential on channels 1, 5, 6, 15)
    localparam int NV = 14;
    localparam logic [6:0] QTAB [NV] = '{
        {5'd0,  1'b1, 1'b0}, {5'd1,  1'b1, 1'b1}, {5'd2,  1'b0, 1'b0},
        {5'd3,  1'b1, 1'b0}, {5'd5,  1'b1, 1'b1}, {5'd6,  1'b0, 1'b0},
        {5'd7,  1'b0, 1'b0}, {5'd8,  1'b1, 1'b0}, {5'd15, 1'b1, 1'b1},
        {5'd16, 1'b0, 1'b0}, {5'd17, 1'b1, 1'b0}, {5'd18, 1'b1, 1'b0},
        {5'd19, 1'b0, 1'b0}, {5'd31, 1'b0, 1'b0}
    };

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_read(logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic query(logic [CW-1:0] c, output logic [1:0] r);
        q_chan = c;
        #1;
        r = {q_legal, q_diff};
    endtask

    initial begin
        logic [DW-1:0] rd;
        logic [1:0]    qr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, rd); check("R1 mode after reset", rd, 32'h0);
        reg_read(2'd1, rd); check("R1 status after reset", rd, 32'h0);

        // R2/R3: write with reserved and fixed bits set
        reg_write(2'd0, 32'h0002_8063);
        reg_read(2'd0, rd); check("R2 R3 mode readback", rd, 32'h0000_8062);

        // R7 R8 R9 table walk
        for (int i = 0; i < NV; i++) begin
            query(QTAB[i][6:2], qr);
            check($sformatf("R7 R8 R9 query ch%0d", QTAB[i][6:2]),
                  {30'd0, qr}, {30'd0, QTAB[i][1:0]});
        end

        // R4 R5: write while converter enabled
        @(negedge clk); conv_en = 1'b1;
        reg_write(2'd0, 32'h0000_0002);
        reg_read(2'd0, rd); check("R4 locked write ignored", rd, 32'h0000_8062);
        query(5'd2, qr); check("R4 ch2 still taken", {30'd0, qr}, 32'd0);
        reg_read(2'd1, rd); check("R5 lock flag set", rd, 32'h1);
        @(negedge clk); conv_en = 1'b0;
        @(negedge clk);
        reg_read(2'd1, rd); check("R5 lock flag sticky", rd, 32'h1);

        // R6: write 0 keeps, write 1 clears
        reg_write(2'd1, 32'h0);
        reg_read(2'd1, rd); check("R6 zero write keeps flag", rd, 32'h1);
        reg_write(2'd1, 32'h1);
        reg_read(2'd1, rd); check("R6 flag cleared", rd, 32'h0);

        // R10 unmapped addresses
        reg_read(2'd2, rd); check("R10 addr2 reads zero", rd, 32'h0);
        reg_read(2'd3, rd); check("R10 addr3 reads zero", rd, 32'h0);

        // R2 R3 all-ones write, border at channel 15/16
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, rd); check("R2 R3 all-ones readback", rd, 32'h0000_FFFE);
        query(5'd16, qr); check("R8 ch16 taken by ch15", {30'd0, qr}, 32'd0);
        query(5'd17, qr); check("R3 R9 ch17 legal single", {30'd0, qr}, 32'd2);
        query(5'd18, qr); check("R3 R9 ch18 legal single", {30'd0, qr}, 32'd2);
        query(5'd1, qr);  check("R9 ch1 legal diff", {30'd0, qr}, 32'd3);
        query(5'd2, qr);  check("R8 ch2 taken", {30'd0, qr}, 32'd0);

        // R2: back to all single-ended
        reg_write(2'd0, 32'h0);
        query(5'd16, qr); check("R2 ch16 freed", {30'd0, qr}, 32'd2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule